// File: doc/BRIEF.md
# Precise Exception Control Unit

This block steers a five-stage in-order pipeline when an instruction faults. Two stages can raise a request. Decode raises one for an undefined opcode, and execute raises one for an arithmetic overflow. Each request comes with the PC of the instruction that raised it. In the same cycle the block chooses one request and flushes the faulting instruction and every younger instruction. It also sends the fetch PC to a handler. On the next clock edge it records the faulting PC plus four and a one-bit cause code.

The block runs in one of two handler modes. In single-entry mode every fault goes to one fixed address. In vectored mode each cause has its own entry, spaced at a fixed step from a base address. A return-from-exception input sends fetch back to the saved PC. Handler software adjusts that saved value before it returns.

The flush and redirect outputs are combinational. They are valid in the cycle the request is seen, so the handler's first fetch happens in the following cycle. Instructions older than the faulting one are never flushed and complete normally.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is held and after it is released, `epc_o` and `cause_o` read zero. With no request present, every flush output and `redirect_o` read zero, and `redirect_pc_o` reads zero.
- R2: An overflow request from execute is always accepted. In the same cycle it raises `exc_taken_o`, `flush_if_o`, `flush_id_o`, `flush_ex_o` and `redirect_o`, so the faulting instruction never writes its destination.
- R3: An undefined-opcode request from decode, with no execute request present, is accepted. It raises `flush_if_o` and `flush_id_o` but leaves `flush_ex_o` low, so the older instruction in execute completes.
- R4: On the clock edge that ends a cycle with an accepted exception, `epc_o` loads the faulting PC plus 4 (modulo 2^32). `cause_o` loads 0 for an undefined opcode and 1 for an overflow.
- R5: With `vec_mode_i` = 0, an accepted exception sets `redirect_pc_o` to 0x8000_0180.
- R6: With `vec_mode_i` = 1, an accepted exception sets `redirect_pc_o` to 0xC000_0000 + 0x20 × cause. That is 0xC000_0000 for an undefined opcode and 0xC000_0020 for an overflow.
- R7: When execute and decode both raise requests in the same cycle, the execute request is the one taken. The decode request comes from an instruction that is already being flushed, so it is ignored. The saved PC is the execute PC plus 4 and the cause is 1.
- R8: `epc_o` and `cause_o` keep their values across every cycle in which no exception is accepted, including cycles with a return request.
- R9: A return request (`eret_i`) with no accepted exception raises `redirect_o` and `flush_if_o` only, and sets `redirect_pc_o` to the current `epc_o`. When an exception is accepted in the same cycle, the exception takes priority and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_mode_i | input | 1 | 1 selects vectored handler entries, 0 selects the single entry |
| id_undef_i | input | 1 | Undefined-opcode request from decode |
| id_pc_i | input | 32 | PC of the instruction in decode |
| ex_ovf_i | input | 1 | Overflow request from execute |
| ex_pc_i | input | 32 | PC of the instruction in execute |
| eret_i | input | 1 | Return-from-exception request |
| exc_taken_o | output | 1 | An exception is accepted this cycle |
| flush_if_o | output | 1 | Discard the fetch-stage instruction |
| flush_id_o | output | 1 | Zero the control bits of the decode-stage instruction |
| flush_ex_o | output | 1 | Zero the control bits of the execute-stage instruction |
| redirect_o | output | 1 | Load the fetch PC from `redirect_pc_o` |
| redirect_pc_o | output | 32 | Next fetch address on a redirect, zero otherwise |
| epc_o | output | 32 | Saved PC of the faulting instruction plus 4 |
| cause_o | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
The bench sweeps every combination of the two fault requests, the return request and the handler mode. It tracks the saved PC and cause in its own model.

Several faults would each show up at the ports:
- A priority inverted between stages would save the decode PC and cause 0 when both stages fault at once.
- A flush mask that is too wide would drop the completing older instruction in execute on a decode-only fault.
- A wrong vector step would land the overflow handler at the wrong address.
- Registers that load on a return or on an idle cycle would corrupt the saved PC, and that corruption shows up on the next return address.

A faulting PC of 0xFFFF_FFFC checks that the plus-four wraps to zero.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] pc_t;

  typedef enum logic [0:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  // Saved return point: faulting PC advanced by one instruction.
  function automatic pc_t f_resume_pc(pc_t pc, pc_t step);
    return pc + step;
  endfunction

  // Handler entry for a given cause in vectored mode.
  function automatic pc_t f_vector_pc(pc_t base, pc_t step, cause_e c);
    return base + step * pc_t'(c);
  endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic   ex_req_i,
  input  logic   id_req_i,
  input  logic   ret_req_i,
  output logic   ex_acc_o,
  output logic   id_acc_o,
  output logic   ret_acc_o,
  output logic   any_exc_o,
  output cause_e cause_o
);
  // Oldest instruction (furthest down the pipe) wins; a younger request
  // belongs to an instruction the winner flushes, so it is dropped.
  always_comb begin
    ex_acc_o  = ex_req_i;
    id_acc_o  = id_req_i && !ex_req_i;
    any_exc_o = ex_acc_o || id_acc_o;
    ret_acc_o = ret_req_i && !any_exc_o;
    cause_o   = ex_acc_o ? CAUSE_OVF : CAUSE_UNDEF;
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter pc_t SINGLE_PC = 32'h8000_0180,
  parameter pc_t VEC_BASE  = 32'hC000_0000,
  parameter pc_t VEC_STEP  = 32'h0000_0020
) (
  input  logic   vec_mode_i,
  input  logic   any_exc_i,
  input  logic   ret_acc_i,
  input  cause_e cause_i,
  input  pc_t    epc_i,
  output pc_t    target_o
);
  pc_t handler_pc;

  always_comb begin
    handler_pc = vec_mode_i ? f_vector_pc(VEC_BASE, VEC_STEP, cause_i) : SINGLE_PC;
    if (any_exc_i)      target_o = handler_pc;
    else if (ret_acc_i) target_o = epc_i;
    else                target_o = '0;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter pc_t PC_STEP = 32'd4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ex_acc_i,
  input  logic   id_acc_i,
  input  pc_t    ex_pc_i,
  input  pc_t    id_pc_i,
  input  cause_e cause_i,
  output pc_t    epc_o,
  output cause_e cause_o
);
  pc_t fault_pc;
  logic capture;

  assign capture  = ex_acc_i || id_acc_i;
  assign fault_pc = ex_acc_i ? ex_pc_i : id_pc_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_o   <= '0;
      cause_o <= CAUSE_UNDEF;
    end else if (capture) begin
      epc_o   <= f_resume_pc(fault_pc, PC_STEP);
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter pc_t SINGLE_PC = 32'h8000_0180,
  parameter pc_t VEC_BASE  = 32'hC000_0000,
  parameter pc_t VEC_STEP  = 32'h0000_0020,
  parameter pc_t PC_STEP   = 32'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vec_mode_i,
  input  logic        id_undef_i,
  input  logic [31:0] id_pc_i,
  input  logic        ex_ovf_i,
  input  logic [31:0] ex_pc_i,
  input  logic        eret_i,
  output logic        exc_taken_o,
  output logic        flush_if_o,
  output logic        flush_id_o,
  output logic        flush_ex_o,
  output logic        redirect_o,
  output logic [31:0] redirect_pc_o,
  output logic [31:0] epc_o,
  output logic        cause_o
);
  // Named internal events, visible to the bound checker.
  logic   ex_acc, id_acc, ret_acc, any_exc;
  cause_e sel_cause, saved_cause;
  pc_t    epc_q;

  exc_prio u_prio (
    .ex_req_i  (ex_ovf_i),
    .id_req_i  (id_undef_i),
    .ret_req_i (eret_i),
    .ex_acc_o  (ex_acc),
    .id_acc_o  (id_acc),
    .ret_acc_o (ret_acc),
    .any_exc_o (any_exc),
    .cause_o   (sel_cause)
  );

  exc_target #(
    .SINGLE_PC (SINGLE_PC),
    .VEC_BASE  (VEC_BASE),
    .VEC_STEP  (VEC_STEP)
  ) u_target (
    .vec_mode_i (vec_mode_i),
    .any_exc_i  (any_exc),
    .ret_acc_i  (ret_acc),
    .cause_i    (sel_cause),
    .epc_i      (epc_q),
    .target_o   (redirect_pc_o)
  );

  exc_regs #(
    .PC_STEP (PC_STEP)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ex_acc_i (ex_acc),
    .id_acc_i (id_acc),
    .ex_pc_i  (ex_pc_i),
    .id_pc_i  (id_pc_i),
    .cause_i  (sel_cause),
    .epc_o    (epc_q),
    .cause_o  (saved_cause)
  );

  // Flush masks: the faulting stage and everything younger.
  assign exc_taken_o = any_exc;
  assign flush_ex_o  = ex_acc;
  assign flush_id_o  = any_exc;
  assign flush_if_o  = any_exc || ret_acc;
  assign redirect_o  = any_exc || ret_acc;
  assign epc_o       = epc_q;
  assign cause_o     = saved_cause;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        vec_mode_i,
  input logic        id_undef_i,
  input logic [31:0] ex_pc_i,
  input logic        ex_ovf_i,
  input logic        eret_i,
  input logic        exc_taken_o,
  input logic        flush_if_o,
  input logic        flush_id_o,
  input logic        flush_ex_o,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o,
  input logic [31:0] epc_o,
  input logic        cause_o
);
  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (epc_o == 32'd0 && cause_o == 1'b0)); // R1

  AST_EX_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf_i |-> (exc_taken_o && flush_if_o && flush_id_o && flush_ex_o && redirect_o)); // R2

  AST_ID_KEEPS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (id_undef_i && !ex_ovf_i) |-> (flush_id_o && flush_if_o && !flush_ex_o)); // R3

  AST_EX_WINS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf_i |=> (epc_o == $past(ex_pc_i) + 32'd4 && cause_o == 1'b1)); // R7

  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken_o && !vec_mode_i) |-> redirect_pc_o == 32'h8000_0180); // R5

  AST_VECTOR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken_o && vec_mode_i) |-> (redirect_pc_o == (ex_ovf_i ? 32'hC000_0020 : 32'hC000_0000))); // R6

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken_o |=> ($stable(epc_o) && $stable(cause_o))); // R8

  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !ex_ovf_i && !id_undef_i) |-> (redirect_o && redirect_pc_o == epc_o && !flush_id_o)); // R9
endmodule

bind exc_ctrl exc_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vec_mode_i    (vec_mode_i),
  .id_undef_i    (id_undef_i),
  .ex_pc_i       (ex_pc_i),
  .ex_ovf_i      (ex_ovf_i),
  .eret_i        (eret_i),
  .exc_taken_o   (exc_taken_o),
  .flush_if_o    (flush_if_o),
  .flush_id_o    (flush_id_o),
  .flush_ex_o    (flush_ex_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .epc_o         (epc_o),
  .cause_o       (cause_o)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_mode_i = 1'b0;
  logic        id_undef_i = 1'b0;
  logic [31:0] id_pc_i = '0;
  logic        ex_ovf_i = 1'b0;
  logic [31:0] ex_pc_i = '0;
  logic        eret_i = 1'b0;
  logic        exc_taken_o, flush_if_o, flush_id_o, flush_ex_o, redirect_o, cause_o;
  logic [31:0] redirect_pc_o, epc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_epc = '0;
  logic        m_cause = 1'b0;

  always #5 clk = ~clk;

  exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
    .id_undef_i(id_undef_i), .id_pc_i(id_pc_i),
    .ex_ovf_i(ex_ovf_i), .ex_pc_i(ex_pc_i), .eret_i(eret_i),
    .exc_taken_o(exc_taken_o), .flush_if_o(flush_if_o), .flush_id_o(flush_id_o),
    .flush_ex_o(flush_ex_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .epc_o(epc_o), .cause_o(cause_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one stimulus cycle, check combinational outputs, then the registers.
  task automatic step(input bit vec, input bit ex, input bit id, input bit er,
                      input logic [31:0] xpc, input logic [31:0] dpc);
    bit exc;
    logic [31:0] tgt;
    @(negedge clk);
    vec_mode_i = vec; ex_ovf_i = ex; id_undef_i = id; eret_i = er;
    ex_pc_i = xpc; id_pc_i = dpc;
    #1;
    exc = ex | id;
    if (exc) tgt = vec ? (32'hC000_0000 + 32'h20 * {31'd0, ex}) : 32'h8000_0180;
    else if (er) tgt = m_epc;
    else tgt = 32'd0;
    chk(ex ? "R2 taken" : (id ? "R3 taken" : "R1 idle taken"), {31'd0, exc_taken_o}, {31'd0, exc});
    chk(ex ? "R2 flush_ex" : "R3 flush_ex", {31'd0, flush_ex_o}, {31'd0, ex});
    chk("R3 flush_id", {31'd0, flush_id_o}, {31'd0, exc});
    chk(er && !exc ? "R9 flush_if" : "R2 flush_if", {31'd0, flush_if_o}, {31'd0, exc | er});
    chk(er && !exc ? "R9 redirect" : "R2 redirect", {31'd0, redirect_o}, {31'd0, exc | er});
    if (exc) chk(vec ? "R6 vector target" : "R5 single target", redirect_pc_o, tgt);
    else     chk(er ? "R9 return target" : "R1 idle target", redirect_pc_o, tgt);
    if (exc) begin
      m_epc   = (ex ? xpc : dpc) + 32'd4;
      m_cause = ex;
    end
    @(posedge clk);
    #1;
    chk(exc ? (ex && id ? "R7 epc" : "R4 epc") : "R8 epc hold", epc_o, m_epc);
    chk(exc ? (ex && id ? "R7 cause" : "R4 cause") : "R8 cause hold", {31'd0, cause_o}, {31'd0, m_cause});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset epc", epc_o, 32'd0);
    chk("R1 reset cause", {31'd0, cause_o}, 32'd0);
    chk("R1 reset redirect", {31'd0, redirect_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // Return with zeroed state goes to zero; registers hold (R8, R9).
    step(1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
    // Full sweep of mode and request combinations, twice with different PCs.
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 16; k++) begin
        step(k[3], k[2], k[1], k[0],
             32'h0000_2000 + 32'(pass * 256 + k * 8),
             32'h0000_4004 + 32'(pass * 512 + k * 12));
        // Follow with a lone return to expose the saved PC at the ports.
        step(k[3], 1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
      end
    end
    // R4: wraparound of PC + 4.
    step(1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC, 32'h0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFFC);
    step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
    // R8: several idle cycles keep state.
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule